// File: doc/BRIEF.md
# Bitmap Video Scanout with Palette

The block scans a full-bitmap frame buffer held in shared system memory and turns it into one 6-bit RGB colour code per pixel clock, together with horizontal sync, vertical sync and a blank flag for a composite-style raster. It runs its own raster counters. During the visible part of each active line it reads frame-buffer bytes through a simple synchronous read port. A shift serializer unpacks each byte into pixels of 1, 2 or 4 bits, most significant pixel first, and each pixel value is used only as an index into a 16-entry palette of 2-bit-per-gun colours.

A fine horizontal scroll delays the visible line by 0 to 7 pixels. The fetch starts four pixels ahead of the window, and the four outermost pixels at each edge of the window are always blanked, so a scrolled line never shows partial data. Software sets the display mode (pixel depth and palette base bits), the scroll, the palette, the frame base address and the line stride through a small write-only register port. Mode, scroll and palette writes are applied at the next line boundary, so graphics and text regions of different depth can share a frame. The line fetch address starts at the frame base at vertical sync and steps by the stride after every active line.

Top module: `bitmap_scanout`

## Requirements
- R1: hsync_o is high for HS_WIDTH pixel positions starting at raster position HS_START of every line; vsync_o is high for the whole of lines VS_START to VS_START+VS_WIDTH-1; a frame is V_TOTAL lines of H_TOTAL positions.
- R2: blank_o is low exactly on lines 0 to V_ACTIVE-1 at raster positions H_START+4 to H_START+H_ACTIVE-5; whenever blank_o is high, rgb_o is zero.
- R3: The mode register (address 0) selects the depth in bits [1:0]: 0 gives 1 bit per pixel, 1 gives 2, 2 and 3 give 4. Bitmap pixel q of a line comes from the byte at offset q*bpp/8 from the line address, pixels taken from bit 7 downward.
- R4: The palette index is {mode[4:2], pixel} at 1 bpp, {mode[3:2], pixel} at 2 bpp and the pixel alone at 4 bpp.
- R5: Palette entry i is written at register address 16+i, data bits [5:0] as red [5:4], green [3:2], blue [1:0]; a visible pixel shows the entry its index selects.
- R6: With scroll value s (register 3, bits [2:0]), window position x (raster position minus H_START) shows bitmap pixel x+4-s.
- R7: Writes to mode, scroll or palette made during a line leave that line unchanged and apply from the following line.
- R8: The frame base (register 1) is loaded as line address at the start of line VS_START; after each active line the line address grows by the stride (register 2); a frame base written during a frame affects only the next frame. Reads within a line use consecutive addresses from the line address.
- R9: Each active line issues exactly H_ACTIVE*bpp/8 reads, never on two consecutive cycles; inactive lines issue none.
- R10: While rst_ni is low, rgb_o is zero, blank_o is high, both syncs are low and no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Register address: 0 mode, 1 frame base, 2 stride, 3 scroll, 16-31 palette |
| wr_data_i | input | 16 | Register write data |
| mem_rd_o | output | 1 | Frame-buffer read request |
| mem_addr_o | output | ADDR_W | Frame-buffer byte address |
| mem_rdata_i | input | 8 | Read data, valid the cycle after the request |
| rgb_o | output | 6 | Pixel colour, 2 bits per gun |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| blank_o | output | 1 | High outside the visible window |

## Verification
Every video output lags the internal raster counter by two cycles, and read data is expected one cycle after its address, so the bench takes the first cycle with vsync_o high as position 0 of line VS_START and from there predicts sync, blank and colour for every following cycle, sampling on falling edges. Read requests are counted per line and their addresses compared with the line address predicted from base and stride. Register writes are issued in mid-line and the bench switches its own copy of mode, scroll and palette only at the next line start, so a premature or late update shows up on the first visible pixel of the affected line.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int PAL_N = 16;
  localparam int COL_W = 6;
  localparam int PIX_W = 4;
  localparam int DLY_N = 8;

  localparam logic [4:0] REG_MODE   = 5'd0;
  localparam logic [4:0] REG_BASE   = 5'd1;
  localparam logic [4:0] REG_STRIDE = 5'd2;
  localparam logic [4:0] REG_SCROLL = 5'd3;
  localparam logic [4:0] REG_PAL    = 5'd16;

  typedef struct packed {
    logic [2:0] base;
    logic [1:0] bpp_sel;
  } mode_t;

  // log2 of bits per pixel: 1->0, 2->1, 4->2
  function automatic logic [1:0] bpp_log2(logic [1:0] sel);
    case (sel)
      2'd0:    return 2'd0;
      2'd1:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/scan_timing.sv
module scan_timing #(
  parameter int H_TOTAL  = 256,
  parameter int H_ACTIVE = 160,
  parameter int H_START  = 48,
  parameter int HS_START = 8,
  parameter int HS_WIDTH = 16,
  parameter int V_TOTAL  = 262,
  parameter int V_ACTIVE = 200,
  parameter int VS_START = 220,
  parameter int VS_WIDTH = 3,
  parameter int HW       = $clog2(H_TOTAL)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [HW-1:0] hcnt_o,
  output logic          line_end_o,
  output logic          vis_line_o,
  output logic          reload_o,
  output logic          hs_o,
  output logic          vs_o,
  output logic          win_o
);
  localparam int VW = $clog2(V_TOTAL);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [HW-1:0] HS_A   = HW'(HS_START);
  localparam logic [HW-1:0] HS_B   = HW'(HS_START + HS_WIDTH);
  localparam logic [HW-1:0] WIN_A  = HW'(H_START + 4);
  localparam logic [HW-1:0] WIN_B  = HW'(H_START + H_ACTIVE - 4);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);
  localparam logic [VW-1:0] V_ACT  = VW'(V_ACTIVE);
  localparam logic [VW-1:0] VS_A   = VW'(VS_START);
  localparam logic [VW-1:0] VS_B   = VW'(VS_START + VS_WIDTH);

  logic [VW-1:0] vcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_o <= '0;
      vcnt_q <= '0;
    end else if (line_end_o) begin
      hcnt_o <= '0;
      vcnt_q <= (vcnt_q == V_LAST) ? '0 : vcnt_q + 1'b1;
    end else begin
      hcnt_o <= hcnt_o + 1'b1;
    end
  end

  always_comb begin
    line_end_o = (hcnt_o == H_LAST);
    vis_line_o = (vcnt_q < V_ACT);
    reload_o   = (hcnt_o == '0) && (vcnt_q == VS_A);
    hs_o       = (hcnt_o >= HS_A) && (hcnt_o < HS_B);
    vs_o       = (vcnt_q >= VS_A) && (vcnt_q < VS_B);
    win_o      = vis_line_o && (hcnt_o >= WIN_A) && (hcnt_o < WIN_B);
  end

  // R1
  vs_line_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_end_o |=> $stable(vs_o));
endmodule

// File: rtl/scan_regs.sv
module scan_regs
  import scan_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [4:0]                  wr_addr_i,
  input  logic [15:0]                 wr_data_i,
  input  logic                        line_end_i,
  output mode_t                       mode_o,
  output logic [2:0]                  scroll_o,
  output logic [PAL_N-1:0][COL_W-1:0] pal_o,
  output logic [ADDR_W-1:0]           base_o,
  output logic [ADDR_W-1:0]           stride_o
);
  mode_t                       mode_sh;
  logic [2:0]                  scroll_sh;
  logic [PAL_N-1:0][COL_W-1:0] pal_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_sh   <= '0;
      scroll_sh <= '0;
      base_o    <= '0;
      stride_o  <= ADDR_W'(20);
    end else if (wr_en_i) begin
      case (wr_addr_i)
        REG_MODE:   mode_sh   <= mode_t'(wr_data_i[4:0]);
        REG_BASE:   base_o    <= wr_data_i[ADDR_W-1:0];
        REG_STRIDE: stride_o  <= wr_data_i[ADDR_W-1:0];
        REG_SCROLL: scroll_sh <= wr_data_i[2:0];
        default: ;
      endcase
    end
  end

  // active copies follow the shadows only at a line boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o   <= '0;
      scroll_o <= '0;
    end else if (line_end_i) begin
      mode_o   <= mode_sh;
      scroll_o <= scroll_sh;
    end
  end

  for (genvar i = 0; i < PAL_N; i++) begin : g_pal
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pal_sh[i] <= '0;
        pal_o[i]  <= '0;
      end else begin
        if (wr_en_i && wr_addr_i == (REG_PAL + 5'(i)))
          pal_sh[i] <= wr_data_i[COL_W-1:0];
        if (line_end_i)
          pal_o[i] <= pal_sh[i];
      end
    end
  end

  // R7
  mode_line_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_end_i |=> $stable(mode_o));
  // R7
  scroll_line_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_end_i |=> $stable(scroll_o));
endmodule

// File: rtl/scan_fetch.sv
module scan_fetch
  import scan_pkg::*;
#(
  parameter int H_START  = 48,
  parameter int H_ACTIVE = 160,
  parameter int ADDR_W   = 16,
  parameter int HW       = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HW-1:0]     hcnt_i,
  input  logic              vis_line_i,
  input  logic              line_end_i,
  input  logic              reload_i,
  input  logic [1:0]        bpp_sel_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_rdata_i,
  output logic [PIX_W-1:0]  pix_o
);
  // pixel 0 leaves the shifter 4 pixels before the window; request, memory
  // and load registers put the first request 3 cycles earlier still
  localparam int FS = H_START - 7;
  localparam logic [HW-1:0] FS_L = HW'(FS);
  localparam logic [HW-1:0] FE_L = HW'(FS + H_ACTIVE);

  logic [1:0]        lb;
  logic [2:0]        ppb_m;
  logic [HW-1:0]     pos;
  logic [HW-1:0]     byte_idx;
  logic              fetch_now;
  logic              ld_q;
  logic [7:0]        sh_q;
  logic [ADDR_W-1:0] line_addr_q;

  always_comb begin
    lb = bpp_log2(bpp_sel_i);
    case (lb)
      2'd0:    ppb_m = 3'd7;
      2'd1:    ppb_m = 3'd3;
      default: ppb_m = 3'd1;
    endcase
    pos       = hcnt_i - FS_L;
    byte_idx  = pos >> (2'd3 - lb);
    fetch_now = vis_line_i && (hcnt_i >= FS_L) && (hcnt_i < FE_L)
                && ((pos[2:0] & ppb_m) == 3'd0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_addr_q <= '0;
    end else if (reload_i) begin
      line_addr_q <= base_i;
    end else if (line_end_i && vis_line_i) begin
      line_addr_q <= line_addr_q + stride_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_rd_o   <= 1'b0;
      mem_addr_o <= '0;
      ld_q       <= 1'b0;
      sh_q       <= '0;
    end else begin
      mem_rd_o <= fetch_now;
      if (fetch_now) mem_addr_o <= line_addr_q + ADDR_W'(byte_idx);
      ld_q <= mem_rd_o;
      if (ld_q) sh_q <= mem_rdata_i;
      else      sh_q <= sh_q << (4'd1 << lb);
    end
  end

  always_comb begin
    case (lb)
      2'd0:    pix_o = {3'b000, sh_q[7]};
      2'd1:    pix_o = {2'b00, sh_q[7:6]};
      default: pix_o = sh_q[7:4];
    endcase
  end

  // R9
  no_back_to_back_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o);
endmodule

// File: rtl/scan_out.sv
module scan_out
  import scan_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [PIX_W-1:0]            pix_i,
  input  mode_t                       mode_i,
  input  logic [PAL_N-1:0][COL_W-1:0] pal_i,
  input  logic [2:0]                  scroll_i,
  input  logic                        win_i,
  input  logic                        hs_i,
  input  logic                        vs_i,
  output logic [COL_W-1:0]            rgb_o,
  output logic                        hsync_o,
  output logic                        vsync_o,
  output logic                        blank_o
);
  logic [3:0]                  idx;
  logic [DLY_N-1:0][COL_W-1:0] dly_q;
  logic                        win_q, hs_q, vs_q;

  always_comb begin
    case (bpp_log2(mode_i.bpp_sel))
      2'd0:    idx = {mode_i.base, pix_i[0]};
      2'd1:    idx = {mode_i.base[1:0], pix_i[1:0]};
      default: idx = pix_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dly_q[0] <= '0;
    else         dly_q[0] <= pal_i[idx];
  end

  for (genvar i = 1; i < DLY_N; i++) begin : g_dly
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) dly_q[i] <= '0;
      else         dly_q[i] <= dly_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q   <= 1'b0;
      hs_q    <= 1'b0;
      vs_q    <= 1'b0;
      rgb_o   <= '0;
      hsync_o <= 1'b0;
      vsync_o <= 1'b0;
      blank_o <= 1'b1;
    end else begin
      win_q   <= win_i;
      hs_q    <= hs_i;
      vs_q    <= vs_i;
      hsync_o <= hs_q;
      vsync_o <= vs_q;
      blank_o <= !win_q;
      rgb_o   <= win_q ? dly_q[scroll_i] : '0;
    end
  end

  // R2
  sync_in_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blank_o |-> (!hsync_o && !vsync_o));
endmodule

// File: rtl/bitmap_scanout.sv
module bitmap_scanout
  import scan_pkg::*;
#(
  parameter int H_TOTAL  = 256,
  parameter int H_ACTIVE = 160,
  parameter int H_START  = 48,
  parameter int HS_START = 8,
  parameter int HS_WIDTH = 16,
  parameter int V_TOTAL  = 262,
  parameter int V_ACTIVE = 200,
  parameter int VS_START = 220,
  parameter int VS_WIDTH = 3,
  parameter int ADDR_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [4:0]        wr_addr_i,
  input  logic [15:0]       wr_data_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_rdata_i,
  output logic [5:0]        rgb_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              blank_o
);
  localparam int HW = $clog2(H_TOTAL);

  logic [HW-1:0]               hcnt;
  logic                        line_end, vis_line, reload, hs, vs, win;
  mode_t                       mode;
  logic [2:0]                  scroll;
  logic [PAL_N-1:0][COL_W-1:0] pal;
  logic [ADDR_W-1:0]           base, stride;
  logic [PIX_W-1:0]            pix;

  scan_timing #(
    .H_TOTAL(H_TOTAL), .H_ACTIVE(H_ACTIVE), .H_START(H_START),
    .HS_START(HS_START), .HS_WIDTH(HS_WIDTH), .V_TOTAL(V_TOTAL),
    .V_ACTIVE(V_ACTIVE), .VS_START(VS_START), .VS_WIDTH(VS_WIDTH), .HW(HW)
  ) u_timing (
    .clk_i, .rst_ni, .hcnt_o(hcnt), .line_end_o(line_end),
    .vis_line_o(vis_line), .reload_o(reload), .hs_o(hs), .vs_o(vs), .win_o(win)
  );

  scan_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .line_end_i(line_end),
    .mode_o(mode), .scroll_o(scroll), .pal_o(pal), .base_o(base), .stride_o(stride)
  );

  scan_fetch #(
    .H_START(H_START), .H_ACTIVE(H_ACTIVE), .ADDR_W(ADDR_W), .HW(HW)
  ) u_fetch (
    .clk_i, .rst_ni, .hcnt_i(hcnt), .vis_line_i(vis_line), .line_end_i(line_end),
    .reload_i(reload), .bpp_sel_i(mode.bpp_sel), .base_i(base), .stride_i(stride),
    .mem_rd_o, .mem_addr_o, .mem_rdata_i, .pix_o(pix)
  );

  scan_out u_out (
    .clk_i, .rst_ni, .pix_i(pix), .mode_i(mode), .pal_i(pal), .scroll_i(scroll),
    .win_i(win), .hs_i(hs), .vs_i(vs),
    .rgb_o, .hsync_o, .vsync_o, .blank_o
  );
endmodule

// File: tb/bitmap_scanout_tb.sv
module bitmap_scanout_tb_top;
  localparam int H_TOTAL  = 64;
  localparam int H_ACTIVE = 32;
  localparam int H_START  = 12;
  localparam int HS_START = 2;
  localparam int HS_WIDTH = 4;
  localparam int V_TOTAL  = 10;
  localparam int V_ACTIVE = 6;
  localparam int VS_START = 7;
  localparam int VS_WIDTH = 2;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        wr_en;
  logic [4:0]  wr_addr;
  logic [15:0] wr_data;
  logic        mem_rd_o;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_rdata = 8'h00;
  logic [5:0]  rgb_o;
  logic        hsync_o, vsync_o, blank_o;

  int checks = 0;
  int fails  = 0;

  logic [4:0]  s_mode, a_mode;
  logic [2:0]  s_scroll, a_scroll;
  logic [15:0] s_base, s_stride, line_addr;
  logic [5:0]  s_pal [16];
  logic [5:0]  a_pal [16];
  int cfg_mode [5];
  int cfg_scr  [5];
  int cfg_base [5];
  int cfg_str  [5];

  always #2 clk = ~clk;

  bitmap_scanout #(
    .H_TOTAL(H_TOTAL), .H_ACTIVE(H_ACTIVE), .H_START(H_START),
    .HS_START(HS_START), .HS_WIDTH(HS_WIDTH), .V_TOTAL(V_TOTAL),
    .V_ACTIVE(V_ACTIVE), .VS_START(VS_START), .VS_WIDTH(VS_WIDTH), .ADDR_W(16)
  ) dut_i (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .mem_rd_o, .mem_addr_o, .mem_rdata_i(mem_rdata),
    .rgb_o, .hsync_o, .vsync_o, .blank_o
  );

  function automatic logic [7:0] memf(logic [15:0] a);
    return 8'(int'(a) * 29 + int'(a >> 8) * 7 + 90);
  endfunction

  // synchronous memory: data one cycle after the address
  always @(posedge clk) mem_rdata <= memf(mem_addr_o);

  function automatic logic [5:0] exp_rgb(int v, int h);
    int x, q, lb, bpp, b, j, val, idx;
    logic [7:0] byt;
    x = h - H_START;
    if (v >= V_ACTIVE || x < 4 || x >= H_ACTIVE - 4) return 6'd0;
    q   = x + 4 - int'(a_scroll);
    lb  = (a_mode[1:0] == 2'd0) ? 0 : ((a_mode[1:0] == 2'd1) ? 1 : 2);
    bpp = 1 << lb;
    b   = q >> (3 - lb);
    j   = q & ((8 >> lb) - 1);
    byt = memf(line_addr + 16'(b));
    val = (int'(byt) >> (8 - bpp * (j + 1))) & ((1 << bpp) - 1);
    if (lb == 0)      idx = (int'(a_mode[4:2]) << 1) | val;
    else if (lb == 1) idx = (int'(a_mode[3:2]) << 2) | val;
    else              idx = val;
    return a_pal[idx];
  endfunction

  task automatic wr_set(int a, int d);
    wr_en   = 1'b1;
    wr_addr = 5'(a);
    wr_data = 16'(d);
    case (a)
      0: s_mode   = 5'(d);
      1: s_base   = 16'(d);
      2: s_stride = 16'(d);
      3: s_scroll = 3'(d);
      default: if (a >= 16) s_pal[a-16] = 6'(d);
    endcase
  endtask

  task automatic hooks(int fid, int v, int h);
    if (v == V_ACTIVE && fid < 4) begin
      if (h == 20) wr_set(0, cfg_mode[fid+1]);
      if (h == 21) wr_set(3, cfg_scr[fid+1]);
      if (h == 22) wr_set(1, cfg_base[fid+1]);
      if (h == 23) wr_set(2, cfg_str[fid+1]);
      if (fid == 1 && h == 24) wr_set(16 + 3, 'h2A);
      if (fid == 1 && h == 25) wr_set(16 + 9, 'h15);
    end
    if (fid == 3) begin
      // R7: mid-frame changes, visible from the next line
      if (v == 1 && h == 20) wr_set(0, 5'b000_11);
      if (v == 2 && h == 20) wr_set(3, 6);
      if (v == 2 && h == 21) wr_set(16 + 7, 'h3F);
      if (v == 3 && h == 20) wr_set(0, 5'b001_01);
      // R8: frame base written mid-frame, used from the next frame only
      if (v == 3 && h == 21) wr_set(1, 'h800);
      if (v == 4 && h == 20) wr_set(2, 4);
    end
  endtask

  task automatic walk_frame(int fid, string tag);
    int v, h, nrd, exp_n;
    logic exp_hs, exp_vs, exp_bl;
    logic [5:0] exp_c;
    v = VS_START; h = 0; nrd = 0;
    for (int c = 0; c < V_TOTAL * H_TOTAL; c++) begin
      wr_en = 1'b0;
      if (h == 0) begin
        a_mode = s_mode; a_scroll = s_scroll; a_pal = s_pal; nrd = 0;
        if (v == VS_START) line_addr = s_base;
      end
      exp_hs = (h >= HS_START) && (h < HS_START + HS_WIDTH);
      exp_vs = (v >= VS_START) && (v < VS_START + VS_WIDTH);
      exp_bl = !((v < V_ACTIVE) && (h >= H_START + 4) && (h < H_START + H_ACTIVE - 4));
      exp_c  = exp_rgb(v, h);
      checks++;
      if (hsync_o !== exp_hs || vsync_o !== exp_vs) begin
        fails++;
        $display("FAIL R1 line %0d pos %0d: hs/vs %b%b expected %b%b",
                 v, h, hsync_o, vsync_o, exp_hs, exp_vs);
      end else if (blank_o !== exp_bl) begin
        fails++;
        $display("FAIL R2 line %0d pos %0d: blank %b expected %b", v, h, blank_o, exp_bl);
      end else if (rgb_o !== exp_c) begin
        fails++;
        $display("FAIL %s line %0d pos %0d: rgb %h expected %h", tag, v, h, rgb_o, exp_c);
      end
      if (mem_rd_o === 1'b1) begin
        checks++;
        if (mem_addr_o !== line_addr + 16'(nrd)) begin
          fails++;
          $display("FAIL R8 line %0d read %0d: addr %h expected %h",
                   v, nrd, mem_addr_o, line_addr + 16'(nrd));
        end
        nrd++;
      end
      if (h == H_TOTAL - 1) begin
        exp_n = (v < V_ACTIVE) ?
                (H_ACTIVE >> (3 - ((a_mode[1:0] == 2'd0) ? 0 : ((a_mode[1:0] == 2'd1) ? 1 : 2)))) : 0;
        checks++;
        if (nrd != exp_n) begin
          fails++;
          $display("FAIL R9 line %0d: reads %0d expected %0d", v, nrd, exp_n);
        end
        if (v < V_ACTIVE) line_addr = line_addr + s_stride;
      end
      hooks(fid, v, h);
      @(negedge clk);
      h++;
      if (h == H_TOTAL) begin h = 0; v = (v + 1) % V_TOTAL; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cfg_mode = '{5'b101_00, 5'b010_01, 5'b000_10, 5'b011_00, 5'b011_00};
    cfg_scr  = '{0, 3, 7, 2, 2};
    cfg_base = '{'h100, 'h200, 'h340, 'h400, 'h400};
    cfg_str  = '{16, 8, 24, 16, 16};
    rst_ni = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    // R10
    checks++;
    if (rgb_o !== 6'd0 || blank_o !== 1'b1 || hsync_o !== 1'b0 ||
        vsync_o !== 1'b0 || mem_rd_o !== 1'b0) begin
      fails++;
      $display("FAIL R10 reset: rgb %h blank %b hs %b vs %b rd %b expected 00 1 0 0 0",
               rgb_o, blank_o, hsync_o, vsync_o, mem_rd_o);
    end
    rst_ni = 1'b1;
    for (int i = 0; i < 16; i++) begin
      wr_set(16 + i, (i * 11 + 5) & 63);
      @(negedge clk);
    end
    wr_set(0, cfg_mode[0]); @(negedge clk);
    wr_set(3, cfg_scr[0]);  @(negedge clk);
    wr_set(1, cfg_base[0]); @(negedge clk);
    wr_set(2, cfg_str[0]);  @(negedge clk);
    wr_en = 1'b0;
    while (vsync_o !== 1'b1) @(negedge clk);
    walk_frame(0, "R3 R4 R5");
    walk_frame(1, "R3 R4 R6");
    walk_frame(2, "R3 R5 R6");
    walk_frame(3, "R7");
    walk_frame(4, "R8");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule